// File: doc/BRIEF.md
# SPI Flash Controller

This block sits between a simple request/response bus port and one serial NOR flash device on a single chip select. Three small registers hold the working state. The first is a write-enable bit for the flash. The second picks 3-byte or 4-byte addressing. The third holds the operating mode, a manual chip-select release flag and the command opcode that the mapped modes send.

Software uses the block in one of two ways. In user mode, the flash window is a raw byte pipe. Each byte written is shifted out unchanged, and each byte read clocks one response byte in. Chip select is held by software through the release flag, so a whole command can span many bus accesses. In the mapped modes, each word access to the window becomes a complete serial transaction: opcode, then address, then data. Chip select is dropped after the last byte. The serial side runs in clock mode 0 at half the system clock, on one data line in each direction.

The bus port uses a valid/ready handshake. The master raises `bus_valid` and keeps every request field stable until it sees `bus_ready`. `bus_ready` is a one-cycle pulse, and the handshake completes on that clock edge. `bus_rdata` is valid in the same cycle. The master must drop `bus_valid` or present a new request in the cycle after the pulse. While a serial transfer runs, the request simply waits; this is the only back-pressure.

Top module: `spi_flash_ctrl`

## Requirements
- R1: After reset the configuration register (offset 0x00) reads 0, the address-width register (0x04) reads 0, the control register (0x10) reads 0x0003_0004, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: Register writes store only their defined fields: bit 16 at 0x00 (flash write enable), bit 0 at 0x04 (4-byte address), and at 0x10 bits [1:0] mode, bit 2 release flag, bits [23:16] opcode. All other bits, and all other offsets, read as zero.
- R3: While idle, `spi_cs_n` is 0 exactly when mode is 3 (user) and the release flag is 0.
- R4: In user mode with chip select held, a byte write shifts out `bus_wdata[7:0]` and a word write shifts out four bytes, bits [31:24] first. A write while the enable bit is 0 produces no serial traffic.
- R5: In user mode with chip select held, a byte read returns the received byte in `bus_rdata[7:0]` with upper bits zero. A word read returns four received bytes, the first in bits [31:24]. The bytes sent during a read are 0x00.
- R6: In mode 0, a window read at offset A sends the opcode, then A as 3 bytes (bits [23:0]) or, with 4-byte addressing, as 4 bytes of A zero-extended, most significant first. It then clocks in four data bytes, returns them first-byte-high, and releases chip select.
- R7: In mode 1 the sequence of R6 has one 0x00 dummy byte between the address and the data bytes.
- R8: In mode 2 with the enable bit set, a window write at offset A sends the opcode, the address as in R6 and the four data bytes most significant first, then releases chip select. With the enable bit clear it sends nothing.
- R9: Window accesses that do not match the mode complete with no serial traffic and read data zero. These are writes in modes 0 and 1, reads in mode 2, and any access in user mode while the release flag is set.
- R10: The serial clock idles low, is high for exactly one system clock per bit, toggles only while chip select is asserted, and `spi_mosi` does not change on a rising serial clock edge.
- R11: `bus_ready` is asserted only while `bus_valid` is high and never for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request present; held until `bus_ready` |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_reg | input | 1 | 1 selects the register space, 0 the flash window |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_word | input | 1 | User mode: 1 moves four bytes, 0 one byte |
| bus_addr | input | WIN_AW | Window offset, or register offset in its low bits |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench sweeps the four modes against both address widths and against addresses with all-ones and alternating upper bytes. A controller that dropped the top address byte in 4-byte mode, or sent it in 3-byte mode, would fail. So would one that omitted the fast-read dummy byte, because the returned word would be shifted by one response byte. The enable gate is probed in both user and mapped write modes, and mismatched accesses are checked for absent chip-select pulses. A design that leaked program traffic would show an extra frame. A flash model answers with position-dependent bytes, so a byte-order or capture-start mistake shows up directly in the read data.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_FAST = 2'd1,
    MODE_PROG = 2'd2,
    MODE_USER = 2'd3
  } sfc_mode_e;

  // register offsets and field positions
  localparam int OFS_CFG       = 'h00;
  localparam int OFS_ADRW      = 'h04;
  localparam int OFS_CTRL      = 'h10;
  localparam int CFG_WE_BIT    = 16;
  localparam int ADRW_4B_BIT   = 0;
  localparam int CTRL_STOP_BIT = 2;
  localparam int CTRL_OPC_LSB  = 16;

  localparam logic [7:0] OPC_RESET = 8'h03;

  typedef struct packed {
    logic       we;
    logic       addr4;
    sfc_mode_e  mode;
    logic       stop;
    logic [7:0] opcode;
  } sfc_cfg_t;

endpackage

// File: rtl/sfc_regs.sv
module sfc_regs
  import sfc_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output sfc_cfg_t          cfg
);

  localparam logic [REG_AW-1:0] A_CFG  = REG_AW'(OFS_CFG);
  localparam logic [REG_AW-1:0] A_ADRW = REG_AW'(OFS_ADRW);
  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(OFS_CTRL);

  sfc_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.we     <= 1'b0;
      cfg_q.addr4  <= 1'b0;
      cfg_q.mode   <= MODE_READ;
      cfg_q.stop   <= 1'b1;
      cfg_q.opcode <= OPC_RESET;
    end else if (wr_en) begin
      if (addr == A_CFG)  cfg_q.we    <= wdata[CFG_WE_BIT];
      if (addr == A_ADRW) cfg_q.addr4 <= wdata[ADRW_4B_BIT];
      if (addr == A_CTRL) begin
        cfg_q.mode   <= sfc_mode_e'(wdata[1:0]);
        cfg_q.stop   <= wdata[CTRL_STOP_BIT];
        cfg_q.opcode <= wdata[CTRL_OPC_LSB +: 8];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CFG)  rdata[CFG_WE_BIT]  = cfg_q.we;
    if (addr == A_ADRW) rdata[ADRW_4B_BIT] = cfg_q.addr4;
    if (addr == A_CTRL) begin
      rdata[1:0]                = cfg_q.mode;
      rdata[CTRL_STOP_BIT]      = cfg_q.stop;
      rdata[CTRL_OPC_LSB +: 8]  = cfg_q.opcode;
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^wdata;

  assign cfg = cfg_q;

endmodule

// File: rtl/sfc_shifter.sv
module sfc_shifter #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [BW-1:0] tx_byte,
  input  logic          miso,
  output logic          busy,
  output logic          done,
  output logic [BW-1:0] rx_byte,
  output logic          sclk,
  output logic          mosi
);

  localparam int CNT_W = (BW > 1) ? $clog2(BW) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BW - 1);

  logic          active_q, phase_q, sclk_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BW-1:0] sh_q, rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start) begin
          active_q <= 1'b1;
          phase_q  <= 1'b0;
          cnt_q    <= '0;
          sh_q     <= tx_byte;
        end
      end else if (!phase_q) begin
        // rising edge: flash samples mosi, controller samples miso
        sclk_q  <= 1'b1;
        phase_q <= 1'b1;
        rx_q    <= {rx_q[BW-2:0], miso};
      end else begin
        // falling edge: advance to the next bit
        sclk_q  <= 1'b0;
        phase_q <= 1'b0;
        sh_q    <= {sh_q[BW-2:0], 1'b0};
        cnt_q   <= cnt_q + CNT_W'(1);
        if (cnt_q == LAST) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assign busy    = active_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign sclk    = sclk_q;
  assign mosi    = sh_q[BW-1];

endmodule

// File: rtl/sfc_frame.sv
module sfc_frame
  import sfc_pkg::*;
#(
  parameter int WIN_AW = 26,
  parameter int DATA_B = 4,
  parameter int MAXB   = 10,
  parameter int CW     = 4
) (
  input  sfc_cfg_t                    cfg,
  input  logic                        is_write,
  input  logic                        is_word,
  input  logic [WIN_AW-1:0]           addr,
  input  logic [8*DATA_B-1:0]         wdata,
  output logic [MAXB-1:0][7:0]        seq,
  output logic [CW-1:0]               nbytes,
  output logic [CW-1:0]               rx_first,
  output logic                        go
);

  always_comb begin
    int k;
    logic [31:0] a32;
    a32      = 32'(addr);
    seq      = '0;
    nbytes   = '0;
    rx_first = '0;
    go       = 1'b0;
    k        = 0;
    if (cfg.mode == MODE_USER) begin
      if (!cfg.stop) begin
        if (is_write) begin
          go = cfg.we;
          if (is_word) begin
            for (int b = 0; b < DATA_B; b++) seq[b] = wdata[8*(DATA_B-1-b) +: 8];
            nbytes = CW'(DATA_B);
          end else begin
            seq[0] = wdata[7:0];
            nbytes = CW'(1);
          end
          rx_first = nbytes;
        end else begin
          go       = 1'b1;
          nbytes   = is_word ? CW'(DATA_B) : CW'(1);
          rx_first = '0;
        end
      end
    end else begin
      seq[0] = cfg.opcode;
      k = 1;
      if (cfg.addr4) begin
        seq[k] = a32[31:24];
        k = k + 1;
      end
      seq[k]   = a32[23:16];
      seq[k+1] = a32[15:8];
      seq[k+2] = a32[7:0];
      k = k + 3;
      if (cfg.mode == MODE_FAST) k = k + 1;  // dummy byte left at zero
      if (cfg.mode == MODE_PROG) begin
        go = is_write && cfg.we;
        for (int b = 0; b < DATA_B; b++) seq[k+b] = wdata[8*(DATA_B-1-b) +: 8];
        rx_first = CW'(k + DATA_B);
      end else begin
        go       = !is_write;
        rx_first = CW'(k);
      end
      nbytes = CW'(k + DATA_B);
    end
  end

endmodule

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl
  import sfc_pkg::*;
#(
  parameter int WIN_AW = 26,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_reg,
  input  logic              bus_write,
  input  logic              bus_word,
  input  logic [WIN_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int DW         = 32;
  localparam int DATA_B     = DW / 8;
  localparam int ADDR_B_MAX = 4;
  localparam int MAXB       = 1 + ADDR_B_MAX + 1 + DATA_B;
  localparam int CW         = $clog2(MAXB + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT, ST_RESP} st_e;

  st_e                  st_q;
  sfc_cfg_t             cfg_q;
  logic [DW-1:0]        reg_rdata;
  logic                 reg_we;
  logic [MAXB-1:0][7:0] fr_seq, tx_q;
  logic [CW-1:0]        fr_n, fr_rxf, nb_q, rxf_q, idx_q;
  logic                 fr_go, dir_cs_q;
  logic [DW-1:0]        rdata_q;
  logic                 sh_start, sh_busy, sh_done;
  logic [7:0]           sh_rx;

  assign reg_we = (st_q == ST_IDLE) && bus_valid && bus_reg && bus_write;

  sfc_regs #(.REG_AW(REG_AW), .DW(DW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_we),
    .addr  (bus_addr[REG_AW-1:0]),
    .wdata (bus_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg_q)
  );

  sfc_frame #(.WIN_AW(WIN_AW), .DATA_B(DATA_B), .MAXB(MAXB), .CW(CW)) u_frame (
    .cfg      (cfg_q),
    .is_write (bus_write),
    .is_word  (bus_word),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .seq      (fr_seq),
    .nbytes   (fr_n),
    .rx_first (fr_rxf),
    .go       (fr_go)
  );

  sfc_shifter #(.BW(8)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sh_start),
    .tx_byte (tx_q[idx_q]),
    .miso    (spi_miso),
    .busy    (sh_busy),
    .done    (sh_done),
    .rx_byte (sh_rx),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      tx_q     <= '0;
      nb_q     <= '0;
      rxf_q    <= '0;
      idx_q    <= '0;
      dir_cs_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (bus_valid) begin
          rdata_q <= '0;
          if (bus_reg) begin
            if (!bus_write) rdata_q <= reg_rdata;
            st_q <= ST_RESP;
          end else if (fr_go) begin
            tx_q     <= fr_seq;
            nb_q     <= fr_n;
            rxf_q    <= fr_rxf;
            idx_q    <= '0;
            dir_cs_q <= (cfg_q.mode != MODE_USER);
            st_q     <= ST_LOAD;
          end else begin
            st_q <= ST_RESP;
          end
        end
        ST_LOAD: st_q <= ST_WAIT;
        ST_WAIT: if (sh_done) begin
          if (idx_q >= rxf_q) rdata_q <= {rdata_q[DW-9:0], sh_rx};
          if (idx_q == nb_q - CW'(1)) begin
            dir_cs_q <= 1'b0;
            st_q     <= ST_RESP;
          end else begin
            idx_q <= idx_q + CW'(1);
            st_q  <= ST_LOAD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic unused_busy;
  assign unused_busy = sh_busy;

  assign sh_start  = (st_q == ST_LOAD);
  assign bus_ready = (st_q == ST_RESP);
  assign bus_rdata = rdata_q;
  assign spi_cs_n  = !(dir_cs_q || (cfg_q.mode == MODE_USER && !cfg_q.stop));

endmodule

// File: rtl/spi_flash_ctrl_chk.sv
module spi_flash_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_valid,
  input logic       bus_ready,
  input logic       spi_cs_n,
  input logic       spi_sclk,
  input logic       spi_mosi,
  input logic [1:0] mode,
  input logic       we
);

  // R10
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R10
  sclk_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |=> !spi_sclk);

  // R10
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));

  // R11
  ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> bus_valid);

  // R11
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  // R8
  no_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !we) |-> spi_cs_n);

endmodule

bind spi_flash_ctrl spi_flash_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .spi_cs_n  (spi_cs_n),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .mode      (cfg_q.mode),
  .we        (cfg_q.we)
);

// File: tb/spi_flash_ctrl_tb.sv
`timescale 1ns/1ps
module spi_flash_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_reg = 1'b0, bus_write = 1'b0, bus_word = 1'b0;
  logic [25:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  spi_flash_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_reg(bus_reg), .bus_write(bus_write), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // ---------------- flash model: logs bytes, answers by position ----------
  logic [7:0] log_b [32];
  int nlog = 0, bitpos = 0, frames = 0, sclk_bad = 0;
  logic [7:0] cur_in = '0;
  logic prev_sclk = 1'b0;

  function automatic logic [7:0] resp(input int i);
    return 8'hC0 ^ 8'(i);
  endfunction

  always @(negedge spi_cs_n) begin
    logic [7:0] r;
    bitpos = 0; nlog = 0;
    r = resp(0);
    spi_miso = r[7];
  end
  always @(posedge spi_cs_n) frames++;
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    cur_in = {cur_in[6:0], spi_mosi};
    bitpos++;
    if (bitpos % 8 == 0) begin
      if (nlog < 32) log_b[nlog] = cur_in;
      nlog++;
    end
  end
  always @(negedge spi_sclk) if (!spi_cs_n) begin
    logic [7:0] r;
    r = resp(bitpos / 8);
    spi_miso = r[7 - (bitpos % 8)];
  end
  always @(negedge clk) begin
    if (spi_sclk && prev_sclk) sclk_bad++;
    if (spi_sclk && spi_cs_n) sclk_bad++;
    prev_sclk = spi_sclk;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic is_reg, input logic wr, input logic wd,
                     input logic [25:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge clk);
    bus_valid = 1'b1; bus_reg = is_reg; bus_write = wr; bus_word = wd;
    bus_addr = a; bus_wdata = d;
    do @(negedge clk); while (!bus_ready);
    r = bus_rdata;
    @(negedge clk);
    chk(bus_ready == 1'b0, "R11", 32'(bus_ready), 0);
    bus_valid = 1'b0;
  endtask

  task automatic wreg(input int ofs, input logic [31:0] v);
    logic [31:0] r;
    bus(1'b1, 1'b1, 1'b1, 26'(ofs), v, r);
  endtask

  task automatic rreg(input int ofs, output logic [31:0] v);
    bus(1'b1, 1'b0, 1'b1, 26'(ofs), 32'h0, v);
  endtask

  logic [7:0] exp_b [32];
  int exp_n;

  task automatic check_frame(input string req);
    chk(nlog == exp_n, req, 32'(nlog), 32'(exp_n));
    for (int i = 0; i < exp_n && i < 32; i++)
      chk(log_b[i] == exp_b[i], req, 32'(log_b[i]), 32'(exp_b[i]));
  endtask

  function automatic logic [31:0] ctrl_val(input logic [7:0] opc, input logic stop,
                                           input logic [1:0] mode);
    return {8'h0, opc, 13'h0, stop, mode};
  endfunction

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  logic [25:0] addrs [4] = '{26'h0000000, 26'h3FFFFFC, 26'h15A5A58, 26'h2C3C3C0};
  logic [31:0] pats [3]  = '{32'hFFFFFFFF, 32'hA5A5A5A5, 32'h5A5A5A5A};

  initial begin
    logic [31:0] r, a32, d;
    int f0, k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(spi_cs_n == 1'b1, "R1", 32'(spi_cs_n), 1);
    chk(spi_sclk == 1'b0, "R1", 32'(spi_sclk), 0);
    rreg('h00, r); chk(r == 32'h0, "R1", r, 32'h0);
    rreg('h04, r); chk(r == 32'h0, "R1", r, 32'h0);
    rreg('h10, r); chk(r == 32'h00030004, "R1", r, 32'h00030004);

    // R2 field masks and unused offsets
    foreach (pats[p]) begin
      wreg('h00, pats[p]); rreg('h00, r);
      chk(r == (pats[p] & 32'h00010000), "R2", r, pats[p] & 32'h00010000);
      wreg('h04, pats[p]); rreg('h04, r);
      chk(r == (pats[p] & 32'h00000001), "R2", r, pats[p] & 32'h00000001);
      wreg('h10, pats[p] | 32'h4); rreg('h10, r);
      chk(r == ((pats[p] | 32'h4) & 32'h00FF0007), "R2", r, (pats[p] | 32'h4) & 32'h00FF0007);
    end
    wreg('h08, 32'hFFFFFFFF);
    for (int o = 'h08; o <= 'h1C; o += 4) if (o != 'h10) begin
      rreg(o, r); chk(r == 0, "R2", r, 0);
    end
    wreg('h00, 0); wreg('h04, 0); wreg('h10, 32'h00030004);

    // R3 chip select by mode and release flag
    for (int m = 0; m < 4; m++) for (int s = 0; s < 2; s++) begin
      wreg('h10, ctrl_val(8'h03, 1'(s), 2'(m)));
      @(negedge clk);
      chk(spi_cs_n == !(m == 3 && s == 0), "R3", 32'(spi_cs_n), 32'(!(m == 3 && s == 0)));
    end
    wreg('h10, ctrl_val(8'h03, 1'b1, 2'd3));

    // R9 user mode with chip select released
    f0 = frames;
    bus(1'b0, 1'b0, 1'b1, 26'h0, 0, r);
    chk(r == 0, "R9", r, 0);
    chk(frames == f0, "R9", 32'(frames), 32'(f0));

    // R4 user writes, gated then enabled
    wreg('h00, 0);
    wreg('h10, ctrl_val(8'h03, 1'b0, 2'd3));
    bus(1'b0, 1'b1, 1'b0, 26'h0, 32'hA5, r);
    chk(nlog == 0, "R4", 32'(nlog), 0);
    wreg('h00, 32'h00010000);
    for (int i = 0; i < 6; i++) begin
      d = 32'((i * 37 + 5) & 8'hFF) | 32'hDEAD0000;
      bus(1'b0, 1'b1, 1'b0, 26'h0, d, r);
      exp_b[i] = d[7:0];
    end
    bus(1'b0, 1'b1, 1'b1, 26'h0, 32'h11223344, r);
    exp_b[6] = 8'h11; exp_b[7] = 8'h22; exp_b[8] = 8'h33; exp_b[9] = 8'h44;
    // R5 user reads
    bus(1'b0, 1'b0, 1'b0, 26'h0, 0, r);
    chk(r == 32'(resp(10)), "R5", r, 32'(resp(10)));
    bus(1'b0, 1'b0, 1'b1, 26'h0, 0, r);
    chk(r == {resp(11), resp(12), resp(13), resp(14)}, "R5", r,
        {resp(11), resp(12), resp(13), resp(14)});
    for (int i = 10; i < 15; i++) exp_b[i] = 8'h00;
    exp_n = 15;
    check_frame("R4");
    f0 = frames;
    wreg('h10, ctrl_val(8'h03, 1'b1, 2'd3));
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R3", 32'(spi_cs_n), 1);
    chk(frames == f0 + 1, "R3", 32'(frames), 32'(f0 + 1));

    // R6 / R7 mapped reads over modes, widths and addresses
    for (int m = 0; m < 2; m++) for (int w = 0; w < 2; w++) foreach (addrs[j]) begin
      wreg('h04, 32'(w));
      wreg('h10, ctrl_val(m ? 8'h0B : 8'h03, 1'b1, 2'(m)));
      f0 = frames;
      bus(1'b0, 1'b0, 1'b1, addrs[j], 0, r);
      a32 = 32'(addrs[j]);
      exp_b[0] = m ? 8'h0B : 8'h03; k = 1;
      if (w) begin exp_b[k] = a32[31:24]; k++; end
      exp_b[k] = a32[23:16]; exp_b[k+1] = a32[15:8]; exp_b[k+2] = a32[7:0]; k += 3;
      if (m) begin exp_b[k] = 8'h00; k++; end
      for (int i = 0; i < 4; i++) exp_b[k+i] = 8'h00;
      exp_n = k + 4;
      check_frame(m ? "R7" : "R6");
      chk(r == {resp(k), resp(k+1), resp(k+2), resp(k+3)}, m ? "R7" : "R6", r,
          {resp(k), resp(k+1), resp(k+2), resp(k+3)});
      chk(frames == f0 + 1, "R6", 32'(frames), 32'(f0 + 1));
      chk(spi_cs_n == 1'b1, "R6", 32'(spi_cs_n), 1);
      // R9 write in a read mode
      f0 = frames;
      bus(1'b0, 1'b1, 1'b1, addrs[j], 32'h12345678, r);
      chk(frames == f0, "R9", 32'(frames), 32'(f0));
    end

    // R8 mapped writes
    wreg('h00, 32'h00010000);
    for (int w = 0; w < 2; w++) for (int j = 1; j < 4; j++) begin
      wreg('h04, 32'(w));
      wreg('h10, ctrl_val(8'h02, 1'b1, 2'd2));
      a32 = 32'(addrs[j]);
      d = a32 ^ 32'hABCDEF12;
      f0 = frames;
      bus(1'b0, 1'b1, 1'b1, addrs[j], d, r);
      exp_b[0] = 8'h02; k = 1;
      if (w) begin exp_b[k] = a32[31:24]; k++; end
      exp_b[k] = a32[23:16]; exp_b[k+1] = a32[15:8]; exp_b[k+2] = a32[7:0]; k += 3;
      exp_b[k] = d[31:24]; exp_b[k+1] = d[23:16]; exp_b[k+2] = d[15:8]; exp_b[k+3] = d[7:0];
      exp_n = k + 4;
      check_frame("R8");
      chk(frames == f0 + 1, "R8", 32'(frames), 32'(f0 + 1));
      chk(r == 0, "R8", r, 0);
      // R9 read in write mode
      f0 = frames;
      bus(1'b0, 1'b0, 1'b1, addrs[j], 0, r);
      chk(r == 0, "R9", r, 0);
      chk(frames == f0, "R9", 32'(frames), 32'(f0));
    end
    wreg('h00, 0);
    f0 = frames;
    bus(1'b0, 1'b1, 1'b1, addrs[2], 32'hCAFEF00D, r);
    chk(frames == f0, "R8", 32'(frames), 32'(f0));

    // R10 serial clock shape observed across the whole run
    chk(sclk_bad == 0, "R10", 32'(sclk_bad), 0);

    report();
  end

endmodule